// File: doc/BRIEF.md
# Printer Port Register Block

This block sits on a host's byte-wide register bus and presents a classic printer port made of three registers: a data register, a status register and a control register. Only the three lowest address bits are decoded, so the register set repeats through the address space. The host latches a byte into the data register and then toggles the strobe bit of the control register. A rising strobe, qualified by select-in and init, hands the byte to a downstream output stream as a single-cycle valid pulse. An input latch, loaded from an external 8-bit port, is returned on data reads when the direction bit selects reading.

The attached printer is modelled by a four-state handshake machine whose states are the two top status bits, not-busy (bit 7) and acknowledge (bit 6). The states are `HS_READY` (11), `HS_TAKEN` (01), `HS_ACK_LOW` (00) and `HS_READY_NOACK` (10). The transitions are:
- *force-ready*: a control write with init low sends any state to `HS_READY`.
- *accept*: a qualified strobe-high write moves `HS_READY` to `HS_TAKEN` and `HS_READY_NOACK` to `HS_ACK_LOW`.
- *ack-drop*: a status read with the stored strobe low moves `HS_TAKEN` to `HS_ACK_LOW`.
- *release*: a status read with the stored strobe low moves `HS_ACK_LOW` back to `HS_READY`.

A qualified strobe-low write raises an interrupt flag if the stored control value already has interrupt enable set. Any status read clears that flag. The interrupt output is the flag.

Top module: `prn_port_regs`

## Requirements
- R1: Only bus_addr[2:0] is decoded: offset 0 is data, 1 is status and 2 is control. A read of any other offset returns 0xFF. Writes to offsets other than 0 and 2, including status, change no register.
- R2: After reset, the written data latch and the input latch are both 0xFF, status is 0xD9, control is 0xCC, irq is 0 and out_valid is 0.
- R3: A control write stores the written byte with bits 7:6 forced to 1, and a control read returns it. The fields are: bit5 direction (1 = read), bit4 interrupt enable, bit3 select-in, bit2 init, bit1 auto-linefeed and bit0 strobe.
- R4: A control write with init (bit2) = 0 sets status to 0xD8. This value is not-busy (bit7), acknowledge (bit6), online (bit4) and error-complement (bit3), with paper-out (bit5) and timeout (bit0) clear.
- R5: A control write with init=1, select=1 and strobe=1 clears status bit7. If the stored strobe bit was 0 before that write, out_valid is high for exactly the one cycle after the write's clock edge, and out_byte then equals the data latch.
- R6: A control write with init=1, select=1 and strobe=0 sets the interrupt flag when bit4 of the control value stored before the write is 1. irq follows the flag and is not changed by data writes.
- R7: A status read returns the status value held before the read, and clears the interrupt flag, so that irq is 0 after the read's edge.
- R8: After a status read, if status bit7 is 0 and the stored strobe is 0, the handshake steps: acknowledge 1 becomes 0, and acknowledge 0 becomes acknowledge 1 with bit7 1. Otherwise status is unchanged.
- R9: A data read returns the input latch when the stored direction bit is 1, and the last written data byte otherwise. The input latch loads ext_din when ext_load is high.
- R10: A control write with init=1 and select=0 changes neither status, irq nor out_valid.
- R11: A qualified strobe-high write made while the stored strobe is already 1 still clears status bit7 but does not pulse out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address, low three bits decoded |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ext_din | input | 8 | External byte for the input latch |
| ext_load | input | 1 | Loads ext_din into the input latch |
| out_valid | output | 1 | One-cycle pulse for an emitted byte |
| out_byte | output | 8 | Emitted byte |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that bus_rd and bus_wr are never high in the same cycle. Under that assumption a status read can never coincide with a strobe event or an interrupt set, and the handshake and flag checks depend on this. The bench drives each bus access for exactly one clock through tasks that raise a single strobe at a time and sample read data before the edge. ext_load is applied only through its own task, between bus accesses.

// File: rtl/prn_pkg.sv
package prn_pkg;
    localparam int DEC_W = 3;
    localparam int BYTE_W = 8;

    localparam logic [DEC_W-1:0] OFF_DATA = 3'd0;
    localparam logic [DEC_W-1:0] OFF_STAT = 3'd1;
    localparam logic [DEC_W-1:0] OFF_CTRL = 3'd2;

    // control field positions
    localparam int C_DIR = 5;
    localparam int C_IEN = 4;
    localparam int C_SEL = 3;
    localparam int C_INIT = 2;
    localparam int C_STB = 0;

    localparam logic [BYTE_W-1:0] CTRL_RST = 8'hCC;
    localparam logic [BYTE_W-1:0] CTRL_FIXED = 8'hC0;
    localparam logic [BYTE_W-1:0] BYTE_RST = 8'hFF;
    localparam logic [BYTE_W-1:0] READ_IDLE = 8'hFF;

    // low six status bits: paper-out, online, error-complement, 0, 0, timeout
    localparam logic [5:0] AUX_RST = 6'h19;
    localparam logic [5:0] AUX_READY = 6'h18;

    // handshake state = {not-busy, acknowledge}
    typedef enum logic [1:0] {
        HS_ACK_LOW     = 2'b00,
        HS_TAKEN       = 2'b01,
        HS_READY_NOACK = 2'b10,
        HS_READY       = 2'b11
    } hs_state_t;
endpackage

// File: rtl/prn_handshake_fsm.sv
module prn_handshake_fsm
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_ready,
    input  logic              strobe_set,
    input  logic              poll,
    input  logic              strobe_lvl,
    output logic [BYTE_W-1:0] status_q
);
    hs_state_t st_q, st_nx;
    logic [5:0] aux_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HS_READY;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        if (force_ready) begin
            st_nx = HS_READY;
        end else if (strobe_set) begin
            unique case (st_q)
                HS_READY:       st_nx = HS_TAKEN;
                HS_READY_NOACK: st_nx = HS_ACK_LOW;
                HS_TAKEN:       st_nx = HS_TAKEN;
                HS_ACK_LOW:     st_nx = HS_ACK_LOW;
            endcase
        end else if (poll && !strobe_lvl) begin
            unique case (st_q)
                HS_TAKEN:       st_nx = HS_ACK_LOW;
                HS_ACK_LOW:     st_nx = HS_READY;
                HS_READY:       st_nx = HS_READY;
                HS_READY_NOACK: st_nx = HS_READY_NOACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           aux_q <= AUX_RST;
        else if (force_ready) aux_q <= AUX_READY;
    end

    always_comb status_q = {st_q, aux_q};

    a_r4_force_ready: assert property (@(posedge clk) disable iff (!rst_n)
        force_ready |=> status_q == 8'hD8);
    a_r8_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        poll && !strobe_set && !force_ready && !strobe_lvl && st_q == HS_TAKEN
        |=> st_q == HS_ACK_LOW);
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        poll && !strobe_set && !force_ready && !strobe_lvl && st_q == HS_ACK_LOW
        |=> st_q == HS_READY);
    a_r5_busy_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_set && !force_ready |=> !status_q[7]);
endmodule

// File: rtl/prn_ctrl_reg.sv
module prn_ctrl_reg
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] data_byte,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              ev_force_ready,
    output logic              ev_strobe_high,
    output logic              ev_strobe_low,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte
);
    logic qualified;
    logic ev_emit;

    always_comb begin
        qualified      = wr_en && wdata[C_INIT] && wdata[C_SEL];
        ev_force_ready = wr_en && !wdata[C_INIT];
        ev_strobe_high = qualified && wdata[C_STB];
        ev_strobe_low  = qualified && !wdata[C_STB];
        ev_emit        = ev_strobe_high && !ctrl_q[C_STB];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= CTRL_RST;
        else if (wr_en) ctrl_q <= wdata | CTRL_FIXED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= BYTE_RST;
        end else begin
            out_valid <= ev_emit;
            if (ev_emit) out_byte <= data_byte;
        end
    end

    a_r5_emit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ctrl_q[C_STB] && !$past(ctrl_q[C_STB]));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/prn_irq_flag.sv
module prn_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic pend_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (clr_req) pend_q <= 1'b0;
        else if (set_req) pend_q <= 1'b1;
    end

    a_r6_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_req && !clr_req |=> pend_q);
endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
    import prn_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        ext_din,
    input  logic              ext_load,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    output logic              irq
);
    logic [DEC_W-1:0] off;
    logic addr_hi_unused;
    logic wr_data, wr_ctrl, rd_stat;
    logic [BYTE_W-1:0] data_wr_q, data_in_q, ctrl_q, status_q;
    logic ev_force_ready, ev_strobe_high, ev_strobe_low;

    generate
        if (ADDR_W > DEC_W) begin : g_hi
            assign addr_hi_unused = ^bus_addr[ADDR_W-1:DEC_W];
        end else begin : g_no_hi
            assign addr_hi_unused = 1'b0;
        end
    endgenerate

    always_comb begin
        off     = bus_addr[DEC_W-1:0];
        wr_data = bus_wr && off == OFF_DATA;
        wr_ctrl = bus_wr && off == OFF_CTRL;
        rd_stat = bus_rd && off == OFF_STAT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_wr_q <= BYTE_RST;
            data_in_q <= BYTE_RST;
        end else begin
            if (wr_data)  data_wr_q <= bus_wdata;
            if (ext_load) data_in_q <= ext_din;
        end
    end

    prn_ctrl_reg i_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_ctrl),
        .wdata          (bus_wdata),
        .data_byte      (data_wr_q),
        .ctrl_q         (ctrl_q),
        .ev_force_ready (ev_force_ready),
        .ev_strobe_high (ev_strobe_high),
        .ev_strobe_low  (ev_strobe_low),
        .out_valid      (out_valid),
        .out_byte       (out_byte)
    );

    prn_handshake_fsm i_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .force_ready (ev_force_ready),
        .strobe_set  (ev_strobe_high),
        .poll        (rd_stat),
        .strobe_lvl  (ctrl_q[C_STB]),
        .status_q    (status_q)
    );

    prn_irq_flag i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (ev_strobe_low && ctrl_q[C_IEN]),
        .clr_req (rd_stat),
        .pend_q  (irq)
    );

    always_comb begin
        case (off)
            OFF_DATA: bus_rdata = ctrl_q[C_DIR] ? data_in_q : data_wr_q;
            OFF_STAT: bus_rdata = status_q;
            OFF_CTRL: bus_rdata = ctrl_q;
            default:  bus_rdata = READ_IDLE;
        endcase
    end

    a_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    a_r1_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && off > OFF_CTRL |-> bus_rdata == 8'hFF);
    a_r3_ctrl_top_ones: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && off == OFF_CTRL |-> bus_rdata[7:6] == 2'b11);
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && off == OFF_STAT |=> !irq);
endmodule

// File: tb/test_prn_port_regs.sv
`timescale 1ns/1ps
module test_prn_port_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] ext_din = '0;
    logic       ext_load = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       irq;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prn_port_regs #(.ADDR_W(8)) i_prn_port_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_din(ext_din), .ext_load(ext_load), .out_valid(out_valid),
        .out_byte(out_byte), .irq(irq)
    );

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_LD = 2'd2;
    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] addr;
        logic [7:0] val;
        logic [7:0] exp;
        logic [7:0] req;
    } vec_t;
    localparam int NV = 35;
    localparam vec_t VECS [NV] = '{
        '{K_RD, 8'h00, 8'h00, 8'hFF, 8'd2},  // R2 data latch
        '{K_RD, 8'h01, 8'h00, 8'hD9, 8'd2},  // R2 status
        '{K_RD, 8'h02, 8'h00, 8'hCC, 8'd2},  // R2 control
        '{K_RD, 8'h03, 8'h00, 8'hFF, 8'd1},  // R1 unmapped
        '{K_RD, 8'h06, 8'h00, 8'hFF, 8'd1},  // R1 unmapped
        '{K_WR, 8'h00, 8'h55, 8'h00, 8'd9},
        '{K_RD, 8'h00, 8'h00, 8'h55, 8'd9},  // R9 write latch
        '{K_RD, 8'h08, 8'h00, 8'h55, 8'd1},  // R1 alias
        '{K_WR, 8'h02, 8'h00, 8'h00, 8'd4},
        '{K_RD, 8'h01, 8'h00, 8'hD8, 8'd4},  // R4 forced ready
        '{K_RD, 8'h02, 8'h00, 8'hC0, 8'd3},  // R3 top ones
        '{K_WR, 8'h02, 8'h0D, 8'h00, 8'd5},
        '{K_RD, 8'h01, 8'h00, 8'h58, 8'd5},  // R5 busy
        '{K_RD, 8'h01, 8'h00, 8'h58, 8'd8},  // R8 strobe high holds
        '{K_WR, 8'h02, 8'h0C, 8'h00, 8'd8},
        '{K_RD, 8'h01, 8'h00, 8'h58, 8'd8},  // R8 ack drops next
        '{K_RD, 8'h01, 8'h00, 8'h18, 8'd8},  // R8 release next
        '{K_RD, 8'h01, 8'h00, 8'hD8, 8'd8},  // R8 ready again
        '{K_WR, 8'h02, 8'h2C, 8'h00, 8'd9},
        '{K_LD, 8'h00, 8'hA5, 8'h00, 8'd9},
        '{K_RD, 8'h00, 8'h00, 8'hA5, 8'd9},  // R9 input latch
        '{K_RD, 8'h02, 8'h00, 8'hEC, 8'd3},  // R3 direction stored
        '{K_WR, 8'h02, 8'h0C, 8'h00, 8'd9},
        '{K_RD, 8'h00, 8'h00, 8'h55, 8'd9},  // R9 back to write latch
        '{K_WR, 8'h01, 8'h00, 8'h00, 8'd1},
        '{K_WR, 8'h03, 8'h12, 8'h00, 8'd1},
        '{K_WR, 8'h07, 8'h34, 8'h00, 8'd1},
        '{K_RD, 8'h01, 8'h00, 8'hD8, 8'd1},  // R1 status write ignored
        '{K_RD, 8'h00, 8'h00, 8'h55, 8'd1},  // R1 data untouched
        '{K_RD, 8'h02, 8'h00, 8'hCC, 8'd1},  // R1 control untouched
        '{K_WR, 8'h02, 8'h05, 8'h00, 8'd10},
        '{K_RD, 8'h01, 8'h00, 8'hD8, 8'd10}, // R10 no select
        '{K_WR, 8'h02, 8'h04, 8'h00, 8'd10},
        '{K_RD, 8'h01, 8'h00, 8'hD8, 8'd10}, // R10 no select
        '{K_RD, 8'h02, 8'h00, 8'hC4, 8'd3}   // R3
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ld(input logic [7:0] d);
        @(negedge clk);
        ext_din = d; ext_load = 1'b1;
        @(negedge clk);
        ext_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        logic [7:0] r;
        do_reset();
        check("R2 out_valid", {7'd0, out_valid}, 8'h00);
        check("R2 irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].kind)
                K_WR: wr(VECS[i].addr, VECS[i].val);
                K_LD: ld(VECS[i].val);
                default: begin
                    rd(VECS[i].addr, r);
                    check($sformatf("R%0d vec %0d", VECS[i].req, i), r, VECS[i].exp);
                end
            endcase
        end

        // R5: rising qualified strobe emits the latched byte for one cycle
        wr(8'h00, 8'h3C);
        wr(8'h02, 8'h0C);
        wr(8'h02, 8'h0D);
        check("R5 out_valid pulse", {7'd0, out_valid}, 8'h01);
        check("R5 out_byte", out_byte, 8'h3C);
        @(negedge clk);
        check("R5 pulse ends", {7'd0, out_valid}, 8'h00);
        rd(8'h01, r);
        check("R5 busy after strobe", r, 8'h58);

        // R11: strobe already high -> busy cleared but no emission
        wr(8'h02, 8'h01);
        wr(8'h02, 8'h0D);
        check("R11 no pulse", {7'd0, out_valid}, 8'h00);
        rd(8'h01, r);
        check("R11 busy cleared", r, 8'h58);

        // R6: enable is taken from the stored value
        wr(8'h02, 8'h1C);
        check("R6 stored enable was 0", {7'd0, irq}, 8'h00);
        wr(8'h02, 8'h1C);
        check("R6 irq raised", {7'd0, irq}, 8'h01);
        wr(8'h00, 8'h77);
        check("R6 data write keeps irq", {7'd0, irq}, 8'h01);

        // R7: status read returns pre-read value and clears irq
        rd(8'h01, r);
        check("R7 status value", r, 8'h58);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
        rd(8'h01, r);
        check("R8 ack dropped", r, 8'h18);

        // R2: reset in mid-run
        wr(8'h02, 8'h1C);
        do_reset();
        check("R2 irq after reset", {7'd0, irq}, 8'h00);
        check("R2 out_valid after reset", {7'd0, out_valid}, 8'h00);
        rd(8'h01, r);
        check("R2 status after reset", r, 8'hD9);
        rd(8'h02, r);
        check("R2 control after reset", r, 8'hCC);
        rd(8'h00, r);
        check("R2 data after reset", r, 8'hFF);

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule